// File: doc/BRIEF.md
# Multicycle Floating-Point Issue Hazard Checker

This block is the decode-stage interlock of an in-order pipeline that feeds four execution units. The units are a one-cycle integer unit for ALU operations, loads, stores and branches, a pipelined FP adder, a pipelined FP multiplier, and an FP divider that is not pipelined. In every cycle it receives at most one decoded instruction: a unit class, a destination register and two source registers. It then either issues that instruction or holds it with a stall. The decision is based on the operations still in flight.

Every operation passes through its execute stages and then one memory stage and one write-back stage. There is a single register write port, and the long and short units complete out of order. For these reasons the block keeps a reservation of future write-back cycles, tagged with destinations. From that reservation it derives structural, port, read-after-write and write-after-write stalls. It also reports the latency of each issued operation and announces each write-back on the cycle it happens. The arithmetic and the register file sit elsewhere.

Top module: `fp_issue_ctl`

## Requirements
- R1: After reset, with reset asserted at any point, nothing is in flight. No write-back is announced, and the first instruction of each unit class issues without stalling.
- R2: With `in_valid` low, both `issue` and `stall` are low. With `in_valid` high, exactly one of them is high in the same cycle.
- R3: Unit codes are 0 for integer, 1 for FP multiply, 2 for FP add and 3 for FP divide. `issue_lat` equals the execute cycles plus two: 3, 9, 6 and 26 by default. Exactly that many cycles after the issuing cycle, `wb_valid` is high for one cycle with `wb_dst` equal to the issued destination.
- R4: The multiply and add units are pipelined. Two independent operations to the same one of these units may issue in consecutive cycles.
- R5: The divider is busy for its 24 execute cycles. A divide presented fewer than 24 cycles after the previous divide issued stalls until that distance is reached.
- R6: An instruction stalls if its write-back cycle would coincide with the write-back cycle of an operation already in flight.
- R7: An instruction stalls while an in-flight producer of one of its sources is three or more cycles away from write-back. A producer two cycles or less away is forwarded, so a one-cycle integer producer never stalls its consumer.
- R8: An instruction stalls while an in-flight operation with the same destination would write back no earlier than the new one would.
- R9: An instruction whose destination equals a source of an in-flight operation does not stall for that reason.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| stall | output | 1 | Presented instruction is held this cycle |
| issue | output | 1 | Presented instruction leaves decode this cycle |
| issue_lat | output | LW | Cycles from issue to write-back for the presented unit |
| wb_valid | output | 1 | An operation writes back this cycle |
| wb_dst | output | REG_W | Destination written this cycle |

## Verification
The assertions take for granted that reset is held low from time zero until the first clock edges have passed. They also require the instruction fields to be settled before each rising edge, because `issue` and `stall` are combinational in those fields. The RAW, WAW and divider properties compare the current instruction with the one issued one cycle earlier, so they rely on the fields being driven once per cycle. The stimulus changes inputs only on the falling edge. It drains the pipeline before each scenario, and it holds a stalled instruction unchanged until it issues, so every scenario starts from an empty, known state.

// File: rtl/fpi_pkg.sv
`timescale 1ns/1ps
package fpi_pkg;

  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_MUL = 2'd1,
    U_ADD = 2'd2,
    U_DIV = 2'd3
  } unit_e;

  // memory stage plus write-back stage after the last execute cycle
  localparam int unsigned PIPE_TAIL = 2;

  function automatic int unsigned wb_distance(
    input unit_e u,
    input int unsigned ex_int, input int unsigned ex_mul,
    input int unsigned ex_add, input int unsigned ex_div);
    int unsigned ex;
    case (u)
      U_MUL:   ex = ex_mul;
      U_ADD:   ex = ex_add;
      U_DIV:   ex = ex_div;
      default: ex = ex_int;
    endcase
    return ex + PIPE_TAIL;
  endfunction

  function automatic int unsigned max4(
    input int unsigned a, input int unsigned b,
    input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fpi_wb_ring.sv
`timescale 1ns/1ps
module fpi_wb_ring #(
  parameter int unsigned DEPTH = 27,
  parameter int unsigned REG_W = 5,
  parameter int unsigned LW    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   put,
  input  logic [LW-1:0]          put_lat,
  input  logic [REG_W-1:0]       put_dst,
  output logic [DEPTH-1:0]       slot_v,
  output logic [DEPTH*REG_W-1:0] slot_dst
);
  // slot k describes the write-back k cycles from now; slot 0 is this cycle
  logic [LW-1:0] put_idx;
  assign put_idx = put_lat - LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v   <= '0;
      slot_dst <= '0;
    end else begin
      slot_v   <= {1'b0, slot_v[DEPTH-1:1]};
      slot_dst <= {{REG_W{1'b0}}, slot_dst[DEPTH*REG_W-1:REG_W]};
      if (put) begin
        slot_v[put_idx] <= 1'b1;
        slot_dst[int'(put_idx)*REG_W +: REG_W] <= put_dst;
      end
    end
  end
endmodule

// File: rtl/fpi_div_occupancy.sv
`timescale 1ns/1ps
module fpi_div_occupancy #(
  parameter int unsigned EX_DIV = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(EX_DIV + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= CW'(EX_DIV - 1);
    else if (left_q != '0)   left_q <= left_q - CW'(1);
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/fpi_hazard_scan.sv
`timescale 1ns/1ps
module fpi_hazard_scan #(
  parameter int unsigned DEPTH   = 27,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned LW      = 5,
  parameter int unsigned RAW_MIN = 3
) (
  input  logic [DEPTH-1:0]       slot_v,
  input  logic [DEPTH*REG_W-1:0] slot_dst,
  input  logic [REG_W-1:0]       src1,
  input  logic [REG_W-1:0]       src2,
  input  logic [REG_W-1:0]       dst,
  input  logic [LW-1:0]          lat,
  output logic                   raw_hit,
  output logic                   waw_hit,
  output logic                   port_hit
);
  logic [DEPTH-1:0] raw_vec, waw_vec, port_vec;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [REG_W-1:0] d;
    assign d = slot_dst[k*REG_W +: REG_W];
    if (k >= RAW_MIN) begin : g_raw
      assign raw_vec[k] = slot_v[k] && ((d == src1) || (d == src2));
    end else begin : g_fwd
      assign raw_vec[k] = 1'b0;
    end
    assign waw_vec[k]  = slot_v[k] && (d == dst) && (LW'(k) >= lat);
    assign port_vec[k] = slot_v[k] && (LW'(k) == lat);
  end

  assign raw_hit  = |raw_vec;
  assign waw_hit  = |waw_vec;
  assign port_hit = |port_vec;
endmodule

// File: rtl/fp_issue_ctl.sv
`timescale 1ns/1ps
module fp_issue_ctl
  import fpi_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned EX_INT = 1,
  parameter int unsigned EX_MUL = 7,
  parameter int unsigned EX_ADD = 4,
  parameter int unsigned EX_DIV = 24,
  localparam int unsigned MAX_EX = max4(EX_INT, EX_MUL, EX_ADD, EX_DIV),
  localparam int unsigned DEPTH  = MAX_EX + PIPE_TAIL + 1,
  localparam int unsigned LW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_unit,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             stall,
  output logic             issue,
  output logic [LW-1:0]    issue_lat,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_dst
);
  unit_e unit;
  logic [LW-1:0] lat_now;
  logic [DEPTH-1:0] slot_v;
  logic [DEPTH*REG_W-1:0] slot_dst;
  logic raw_hit, waw_hit, port_hit, div_busy, unit_busy, hazard, div_start;

  assign unit    = unit_e'(in_unit);
  assign lat_now = LW'(wb_distance(unit, EX_INT, EX_MUL, EX_ADD, EX_DIV));

  fpi_hazard_scan #(
    .DEPTH(DEPTH), .REG_W(REG_W), .LW(LW), .RAW_MIN(PIPE_TAIL + 1)
  ) scan_i (
    .slot_v(slot_v), .slot_dst(slot_dst),
    .src1(in_src1), .src2(in_src2), .dst(in_dst), .lat(lat_now),
    .raw_hit(raw_hit), .waw_hit(waw_hit), .port_hit(port_hit)
  );

  fpi_div_occupancy #(.EX_DIV(EX_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start), .busy(div_busy)
  );

  assign unit_busy = (unit == U_DIV) && div_busy;
  assign hazard    = raw_hit | waw_hit | port_hit | unit_busy;
  assign stall     = rst_n & in_valid & hazard;
  assign issue     = rst_n & in_valid & ~hazard;
  assign div_start = issue && (unit == U_DIV);

  fpi_wb_ring #(.DEPTH(DEPTH), .REG_W(REG_W), .LW(LW)) ring_i (
    .clk(clk), .rst_n(rst_n),
    .put(issue), .put_lat(lat_now), .put_dst(in_dst),
    .slot_v(slot_v), .slot_dst(slot_dst)
  );

  assign issue_lat = lat_now;
  assign wb_valid  = slot_v[0];
  assign wb_dst    = slot_dst[REG_W-1:0];
endmodule

// File: rtl/fpi_issue_checker.sv
`timescale 1ns/1ps
module fpi_issue_checker
  import fpi_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_unit,
  input logic [REG_W-1:0] in_dst,
  input logic [REG_W-1:0] in_src1,
  input logic [REG_W-1:0] in_src2,
  input logic             stall,
  input logic             issue
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!issue && !stall)); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (issue ^ stall)); // R2

  AST_DIV_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_unit == U_DIV) |=> !(issue && in_unit == U_DIV)); // R5

  AST_RAW_ADD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && in_unit == U_ADD) && in_valid &&
     (in_src1 == $past(in_dst) || in_src2 == $past(in_dst))) |-> stall); // R7

  AST_WAW_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && in_unit == U_DIV) && in_valid && in_unit == U_INT &&
     in_dst == $past(in_dst)) |-> stall); // R8
endmodule

bind fp_issue_ctl fpi_issue_checker #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
  .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
  .stall(stall), .issue(issue)
);

// File: tb/fp_issue_ctl_tb_top.sv
`timescale 1ns/1ps
module fp_issue_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic stall, issue, wb_valid;
  logic [4:0] issue_lat, wb_dst;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int lat_tab [4] = '{3, 9, 6, 26};   // execute cycles + 2 (R3)
  localparam int DIV_BUSY = 24;

  always #4 clk = ~clk;  // 125 MHz

  fp_issue_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .stall(stall), .issue(issue), .issue_lat(issue_lat),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 2 ns later, before the next rising edge
  task automatic win(input bit v, input int u, input int d, input int s1, input int s2);
    @(negedge clk);
    in_valid = v; in_unit = 2'(u); in_dst = 5'(d); in_src1 = 5'(s1); in_src2 = 5'(s2);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) win(0, 0, 0, 0, 0);
  endtask

  // first cycle (relative to A's issue at 0) in which B may issue
  function automatic int earliest(input int ua, input int ub, input int rel, input int tb);
    int la, lb;
    bit ok;
    la = lat_tab[ua];
    lb = lat_tab[ub];
    for (int c = tb; c < 200; c++) begin
      ok = 1'b1;
      if (ua == 3 && ub == 3 && c < DIV_BUSY) ok = 1'b0;   // R5
      if (c + lb == la) ok = 1'b0;                          // R6
      if (rel == 1 && la - c > 2) ok = 1'b0;                // R7
      if (rel == 2 && la - c >= lb) ok = 1'b0;              // R8
      if (ok) return c;
    end
    return -1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string lbl;
    int cb, cb_act, wb_bad, hs_bad, db, s1b, expd;
    bit a_ok, expv, b_drv;

    rst_n = 1'b0;
    idle(3);
    // R1: empty state during and after reset
    check(!wb_valid && !stall && !issue, "R1 reset outputs", int'(wb_valid), 0);
    rst_n = 1'b1;
    idle(2);
    check(!wb_valid && !stall && !issue, "R2 idle after reset", int'(stall), 0);

    // R3: reported latency per unit code, from an empty pipeline
    for (int u = 0; u < 4; u++) begin
      win(1, u, 10 + u, 20, 21);
      check(issue && !stall, "R1 first issue", int'(issue), 1);
      check(int'(issue_lat) == lat_tab[u], "R3 issue_lat", int'(issue_lat), lat_tab[u]);
      idle(30);
    end

    // R1: reset in the middle of a divide flushes everything
    win(1, 3, 7, 8, 9);
    idle(3);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    wb_bad = 0;
    for (int i = 0; i < 30; i++) begin
      win(0, 0, 0, 0, 0);
      if (wb_valid) wb_bad++;
    end
    check(wb_bad == 0, "R1 flushed write-back", wb_bad, 0);
    win(1, 3, 7, 8, 9);
    check(issue, "R1 divide after flush", int'(issue), 1);
    idle(30);

    // sweep: producer A, follower B, relation, gap
    for (int ua = 0; ua < 4; ua++)
      for (int ub = 0; ub < 4; ub++)
        for (int rel = 0; rel < 4; rel++)
          for (int gap = 0; gap < 4; gap++) begin
            idle(30);
            // A: dst 1, src 2,3. rel 0 none, 1 RAW, 2 WAW, 3 WAR
            db  = (rel == 2) ? 1 : (rel == 3) ? 2 : 4;
            s1b = (rel == 1) ? 1 : 5;
            cb  = earliest(ua, ub, rel, 1 + gap);
            if (ua == 3 && ub == 3) lbl = "R5";
            else if (rel == 0) lbl = (ua == ub) ? "R4" : "R6";
            else if (rel == 1) lbl = "R7";
            else if (rel == 2) lbl = "R8";
            else lbl = "R9";
            cb_act = -1; wb_bad = 0; hs_bad = 0; a_ok = 1'b0;
            for (int w = 0; w < 60; w++) begin
              b_drv = 1'b0;
              if (w == 0) win(1, ua, 1, 2, 3);
              else if (w >= 1 + gap && cb_act < 0) begin
                win(1, ub, db, s1b, 6);
                b_drv = 1'b1;
              end else win(0, 0, 0, 0, 0);
              if (in_valid && (issue == stall)) hs_bad++;
              if (!in_valid && (issue || stall)) hs_bad++;
              if (w == 0) a_ok = issue;
              if (b_drv && issue) cb_act = w;
              expv = (w == lat_tab[ua]) || (w == cb + lat_tab[ub]);
              expd = (w == lat_tab[ua]) ? 1 : db;
              if (wb_valid != expv || (expv && int'(wb_dst) != expd)) wb_bad++;
            end
            check(cb_act == cb, {lbl, " issue cycle"}, cb_act, cb);
            check(wb_bad == 0, "R3 write-back timing", wb_bad, 0);
            check(hs_bad == 0 && a_ok, "R2 issue/stall outcome", hs_bad, 0);
          end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule